// File: doc/BRIEF.md
# Shadowed BCD Calendar Clock

This block keeps time of day and a calendar in packed BCD: hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year. A single-cycle 100 Hz strobe drives it. Inside there are two copies of the time. The working copy advances on every strobe. A second copy is visible to software and is loaded from the working copy at each strobe, so the fields above hundredths move in one transfer when hundredths wraps from 99 to 00.

Software reads and writes the visible copy through a flat byte-wide register port with a write strobe and a combinational read path. Clearing the transfer-enable bit holds the visible copy still, so a multi-byte read or write sees consistent values. The working copy keeps counting during the hold. When transfer is enabled again, only the bytes that software wrote during the hold are pushed into the working copy. The hours byte selects a 12-hour or a 24-hour format. A bit in the month byte stops the clock.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset, addresses 0..7 read 00,00,00,00,01,01,01,00 and the control byte at address 8 reads 0x80.
- R2: Each strobe on `tick_i` advances hundredths (address 0) by one BCD count from 00 to 99 and wraps it to 00. Without a strobe, the time does not change.
- R3: Seconds (address 1) and minutes (address 2) advance only when hundredths wraps from 99. Each wraps from 59 to 00 and carries into the next field.
- R4: Writing 0 to control bit 7 freezes addresses 0..7 while the working copy keeps counting. Writing 1 to that bit makes the reads show the current time again, with no time lost.
- R5: A byte written during the freeze is loaded into the working copy when transfer is enabled again. Bytes that were not written keep their running values.
- R6: In 24-hour mode (hours bit 6 = 0), hours count from 00 to 23 using bits 5:0. Going from 23 to 00 advances the day of week (address 4, 1..7, wrapping to 1) and the date.
- R7: In 12-hour mode (hours bit 6 = 1), bits 4:0 hold 01..12 and bit 5 is PM. The hour goes from 11 to 12 and toggles PM. It goes from 12 to 01 without toggling PM. Going from 11 PM to 12 AM advances the day.
- R8: The date (address 5) wraps to 01 after the last day of the month (address 6, bits 4:0): 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February has 29 days when the year value is divisible by 4, including 00, and 28 otherwise.
- R9: The month wraps from 12 to 01 and carries into the year (address 7), which wraps from 99 to 00.
- R10: While month bit 7 is 1, strobes have no effect on any field. That bit reads back as written.
- R11: Unused bits read as zero. The write masks are 0xFF, 0x7F, 0x7F, 0x7F, 0x07, 0x3F, 0x9F and 0xFF for addresses 0..7, and 0x80 for address 8. Addresses 9..15 read 0.
- R12: While transfer is enabled, a write to a time byte takes effect in both copies and reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz strobe, high for one clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
The range and carry properties assume that every byte written to a time field is a valid BCD value inside that field's legal range. They also assume that writes and strobes never share a clock cycle. The stimulus follows both rules: it loads each case field by field with no strobe pending, then issues strobes one at a time. Expected values come from a binary-integer time model in the bench that is converted to BCD. The sweeps cover every hour in 12-hour mode and the last day and the day before it for every month across leap, non-leap, 00 and 99 years.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NUM_TIME = 8;
  localparam int FIELD_W  = $clog2(NUM_TIME);
  localparam int ADDR_W   = 4;
  localparam int CTRL_IDX = NUM_TIME;

  localparam int F_HUND = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_DAY  = 4;
  localparam int F_DATE = 5;
  localparam int F_MON  = 6;
  localparam int F_YEAR = 7;

  typedef logic [NUM_TIME-1:0][7:0] rtc_time_t;

  localparam rtc_time_t RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h01,
                                      8'h00, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] field_mask(input logic [FIELD_W-1:0] idx);
    case (idx)
      FIELD_W'(F_SEC), FIELD_W'(F_MIN), FIELD_W'(F_HOUR): return 8'h7F;
      FIELD_W'(F_DAY):  return 8'h07;
      FIELD_W'(F_DATE): return 8'h3F;
      FIELD_W'(F_MON):  return 8'h9F;
      default:          return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_inc.sv
`timescale 1ns/1ps
module rtc_bcd_inc #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         en_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam int DIG = W / 4;

  logic [W-1:0] inc;
  logic         c;
  logic [3:0]   nib;

  always_comb begin
    c   = 1'b1;
    nib = '0;
    inc = val_i;
    for (int d = 0; d < DIG; d++) begin
      nib = val_i[4*d +: 4];
      if (c) begin
        if (nib >= 4'd9) begin
          nib = 4'd0;
          c   = 1'b1;
        end else begin
          nib = nib + 4'd1;
          c   = 1'b0;
        end
      end
      inc[4*d +: 4] = nib;
    end
  end

  assign wrap_o = en_i && (val_i >= hi_i);
  assign nxt_o  = !en_i ? val_i : (wrap_o ? lo_i : inc);
endmodule

// File: rtl/rtc_month_len.sv
`timescale 1ns/1ps
module rtc_month_len (
  input  logic [7:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_o
);
  logic [6:0] year_bin;
  logic [7:0] mon_bcd;
  logic       leap;

  assign year_bin = 7'(year_i[7:4]) * 7'd10 + 7'(year_i[3:0]);
  assign leap     = (year_bin[1:0] == 2'b00);
  assign mon_bcd  = mon_i & 8'h1F;

  always_comb begin
    case (mon_bcd)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_advance.sv
`timescale 1ns/1ps
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      step_i,
  output rtc_time_t nxt_o
);
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr, c_unused;
  logic [7:0] hund_n, sec_n, min_n, day_n, date_n, mon_n, year_n;
  logic [7:0] h24_n, h12_n, last_day, hr;
  logic w24, w12_unused, mode12, pm, pm_tog, c_day12;

  rtc_bcd_inc u_hund (.val_i(cur_i[F_HUND]), .lo_i(8'h00), .hi_i(8'h99),
                      .en_i(step_i), .nxt_o(hund_n), .wrap_o(c_sec));
  rtc_bcd_inc u_sec  (.val_i(cur_i[F_SEC]), .lo_i(8'h00), .hi_i(8'h59),
                      .en_i(c_sec), .nxt_o(sec_n), .wrap_o(c_min));
  rtc_bcd_inc u_min  (.val_i(cur_i[F_MIN]), .lo_i(8'h00), .hi_i(8'h59),
                      .en_i(c_min), .nxt_o(min_n), .wrap_o(c_hr));

  // hour: two format-specific counters, result picked by mode bit
  assign hr     = cur_i[F_HOUR];
  assign mode12 = hr[6];
  assign pm     = hr[5];

  rtc_bcd_inc u_h24 (.val_i(hr & 8'h3F), .lo_i(8'h00), .hi_i(8'h23),
                     .en_i(c_hr && !mode12), .nxt_o(h24_n), .wrap_o(w24));
  rtc_bcd_inc u_h12 (.val_i(hr & 8'h1F), .lo_i(8'h01), .hi_i(8'h12),
                     .en_i(c_hr && mode12), .nxt_o(h12_n), .wrap_o(w12_unused));

  assign pm_tog  = c_hr && mode12 && ((hr & 8'h1F) == 8'h11);
  assign c_day12 = pm_tog && pm;
  assign c_day   = mode12 ? c_day12 : w24;

  rtc_bcd_inc u_day (.val_i(cur_i[F_DAY] & 8'h07), .lo_i(8'h01), .hi_i(8'h07),
                     .en_i(c_day), .nxt_o(day_n), .wrap_o(c_unused));

  rtc_month_len u_len (.mon_i(cur_i[F_MON]), .year_i(cur_i[F_YEAR]), .last_o(last_day));

  rtc_bcd_inc u_date (.val_i(cur_i[F_DATE] & 8'h3F), .lo_i(8'h01), .hi_i(last_day),
                      .en_i(c_day), .nxt_o(date_n), .wrap_o(c_mon));
  rtc_bcd_inc u_mon  (.val_i(cur_i[F_MON] & 8'h1F), .lo_i(8'h01), .hi_i(8'h12),
                      .en_i(c_mon), .nxt_o(mon_n), .wrap_o(c_yr));
  rtc_bcd_inc u_year (.val_i(cur_i[F_YEAR]), .lo_i(8'h00), .hi_i(8'h99),
                      .en_i(c_yr), .nxt_o(year_n), .wrap_o());

  always_comb begin
    nxt_o         = cur_i;
    nxt_o[F_HUND] = hund_n;
    nxt_o[F_SEC]  = sec_n;
    nxt_o[F_MIN]  = min_n;
    if (c_hr) begin
      if (mode12) nxt_o[F_HOUR] = {2'b01, pm ^ pm_tog, 5'b0} | h12_n;
      else        nxt_o[F_HOUR] = h24_n;
    end
    nxt_o[F_DAY]  = day_n;
    nxt_o[F_DATE] = date_n;
    nxt_o[F_MON]  = (cur_i[F_MON] & 8'h80) | mon_n;
    nxt_o[F_YEAR] = year_n;
  end
endmodule

// File: rtl/rtc_shadow_clock.sv
`timescale 1ns/1ps
module rtc_shadow_clock
  import rtc_pkg::*;
#(
  parameter int ADDR_W_P = rtc_pkg::ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W_P-1:0] addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o
);
  localparam logic [ADDR_W_P-1:0] CTRL_A = ADDR_W_P'(CTRL_IDX);
  localparam logic [ADDR_W_P-1:0] TIME_N = ADDR_W_P'(NUM_TIME);

  rtc_time_t int_q, int_d, ext_q, ext_d, adv;
  logic [NUM_TIME-1:0] dirty_q, dirty_d;
  logic te_q, te_d;
  logic wr_time, wr_ctrl, te_rise, step;
  logic [FIELD_W-1:0] idx;
  logic [7:0] wval;

  assign idx     = addr_i[FIELD_W-1:0];
  assign wr_time = wr_en_i && (addr_i < TIME_N);
  assign wr_ctrl = wr_en_i && (addr_i == CTRL_A);
  assign te_rise = wr_ctrl && wdata_i[7] && !te_q;
  assign wval    = wdata_i & field_mask(idx);
  assign step    = tick_i && !int_q[F_MON][7];

  rtc_advance u_adv (.cur_i(int_q), .step_i(step), .nxt_o(adv));

  always_comb begin
    int_d   = adv;
    ext_d   = ext_q;
    dirty_d = dirty_q;
    te_d    = wr_ctrl ? wdata_i[7] : te_q;
    if (te_q) begin
      if (wr_time) int_d[idx] = wval;
      ext_d = int_d;
    end else begin
      if (wr_time) begin
        ext_d[idx]   = wval;
        dirty_d[idx] = 1'b1;
      end
      if (te_rise) begin
        // merge only bytes touched during the freeze
        for (int i = 0; i < NUM_TIME; i++)
          if (dirty_q[i]) int_d[i] = ext_q[i];
        dirty_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q   <= RESET_TIME;
      ext_q   <= RESET_TIME;
      dirty_q <= '0;
      te_q    <= 1'b1;
    end else begin
      int_q   <= int_d;
      ext_q   <= ext_d;
      dirty_q <= dirty_d;
      te_q    <= te_d;
    end
  end

  always_comb begin
    if (addr_i < TIME_N)       rdata_o = ext_q[idx];
    else if (addr_i == CTRL_A) rdata_o = {te_q, 7'b0};
    else                       rdata_o = 8'h00;
  end
endmodule

// File: rtl/rtc_shadow_chk.sv
`timescale 1ns/1ps
module rtc_shadow_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W_P = rtc_pkg::ADDR_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                wr_en_i,
  input logic [ADDR_W_P-1:0] addr_i,
  input logic [7:0]          rdata_o,
  input logic                te_q,
  input rtc_time_t           int_q,
  input rtc_time_t           ext_q
);
  AST_TICK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && !int_q[F_MON][7]) |=> (int_q[F_HUND] != $past(int_q[F_HUND]))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(int_q)); // R2
  AST_UPPER_ON_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && int_q[F_HUND] != 8'h99) |=> $stable(int_q[NUM_TIME-1:1])); // R3
  AST_EXT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te_q && !wr_en_i) |=> $stable(ext_q)); // R4
  AST_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_q |=> (ext_q == int_q)); // R12
  AST_OSC_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_q[F_MON][7] && !wr_en_i) |=> $stable(int_q)); // R10
  AST_PM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && int_q[F_HOUR][6] && int_q[F_HOUR][4:0] != 5'h11) |=> $stable(int_q[F_HOUR][5])); // R7
  AST_DATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_q[F_DATE] >= 8'h01 && int_q[F_DATE] <= 8'h31)); // R8
  AST_DAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_q[F_DAY] >= 8'h01 && int_q[F_DAY] <= 8'h07)); // R6
  AST_UNUSED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W_P'(F_DAY)) |-> (rdata_o[7:3] == 5'b0)); // R11
endmodule

bind rtc_shadow_clock rtc_shadow_chk #(.ADDR_W_P(ADDR_W_P)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .te_q(te_q), .int_q(int_q), .ext_q(ext_q));

// File: tb/rtc_shadow_clock_bench.sv
`timescale 1ns/1ps
module rtc_shadow_clock_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // binary model of the time
  int m_hs, m_s, m_m, m_h, m_dow, m_dt, m_mo, m_yr;
  bit m_12, m_osc;
  logic [7:0] frozen [8];

  rtc_shadow_clock u_rtc_shadow_clock (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o));

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    int h12;
    h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
    case (i)
      0: return bcd(m_hs);
      1: return bcd(m_s);
      2: return bcd(m_m);
      3: return m_12 ? (8'h40 | (m_h >= 12 ? 8'h20 : 8'h00) | bcd(h12)) : bcd(m_h);
      4: return bcd(m_dow);
      5: return bcd(m_dt);
      6: return bcd(m_mo) | (m_osc ? 8'h80 : 8'h00);
      default: return bcd(m_yr);
    endcase
  endfunction

  task automatic model_tick();
    if (m_osc) return;
    m_hs++;
    if (m_hs == 100) begin
      m_hs = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_m++;
        if (m_m == 60) begin
          m_m = 0; m_h++;
          if (m_h == 24) begin
            m_h = 0;
            m_dow = (m_dow % 7) + 1;
            if (m_dt == dim(m_mo, m_yr)) begin
              m_dt = 1; m_mo++;
              if (m_mo == 13) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
            end else m_dt++;
          end
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = 4'(a); wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = 4'(a);
    #1 d = rdata_o;
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
      model_tick();
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check(req, v, exp_byte(i));
    end
  endtask

  task automatic set_all(input bit mode12, input int h, input int mi, input int s,
                         input int hs, input int dow, input int dt, input int mo, input int yr);
    m_12 = mode12; m_h = h; m_m = mi; m_s = s; m_hs = hs;
    m_dow = dow; m_dt = dt; m_mo = mo; m_yr = yr;
    for (int i = 0; i < 8; i++) wr(i, exp_byte(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    m_hs = 0; m_s = 0; m_m = 0; m_h = 0; m_dow = 1; m_dt = 1; m_mo = 1; m_yr = 0;
    m_12 = 0; m_osc = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    check_all("R1");
    rd(8, v); check("R1 ctrl", v, 8'h80);

    // R2: every strobe steps hundredths; the carry lands in seconds (R3)
    for (int k = 0; k < 100; k++) begin
      tick_n(1);
      rd(0, v); check("R2 hund", v, bcd(m_hs));
    end
    check_all("R3 after 100 ticks");

    set_all(0, 0, 59, 59, 99, 3, 15, 6, 40);
    tick_n(1); check_all("R3 minute/hour carry");

    set_all(0, 23, 59, 59, 99, 7, 10, 5, 30);
    tick_n(1); check_all("R6 day wrap");

    // R7: every hour in 12-hour mode
    for (int h = 0; h < 24; h++) begin
      set_all(1, h, 59, 59, 99, 2, 20, 8, 51);
      tick_n(1); check_all("R7 12h step");
    end

    // R8/R9: month ends across leap and non-leap years
    foreach (v[b]) begin end
    for (int yi = 0; yi < 4; yi++) begin
      int yr;
      yr = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
      for (int mo = 1; mo <= 12; mo++) begin
        for (int off = 1; off >= 0; off--) begin
          set_all(0, 23, 59, 59, 99, 4, dim(mo, yr) - off, mo, yr);
          tick_n(1);
          check_all((mo == 12 && off == 0) ? "R9 year carry" : "R8 month end");
        end
      end
    end

    // R4: freeze, keep counting, resume
    set_all(0, 10, 20, 58, 50, 5, 12, 3, 44);
    wr(8, 8'h00);
    for (int i = 0; i < 8; i++) frozen[i] = exp_byte(i);
    tick_n(120);
    for (int i = 0; i < 8; i++) begin rd(i, v); check("R4 frozen", v, frozen[i]); end
    rd(8, v); check("R4 ctrl", v, 8'h00);
    wr(8, 8'h80);
    check_all("R4 resume");

    // R5: byte written during the freeze is merged at resume
    set_all(0, 5, 10, 20, 0, 1, 9, 9, 9);
    wr(8, 8'h00);
    wr(2, 8'h30);
    rd(2, v); check("R5 frozen write", v, 8'h30);
    tick_n(5);
    wr(8, 8'h80);
    m_m = 30;
    check_all("R5 merge");

    // R10: oscillator stop
    m_osc = 1;
    wr(6, exp_byte(6));
    tick_n(50);
    check_all("R10 halted");
    m_osc = 0;
    wr(6, exp_byte(6));
    tick_n(1);
    check_all("R10 resumed");

    // R11: masked bits and unmapped addresses
    wr(4, 8'hFF); m_dow = 7;
    rd(4, v); check("R11 day mask", v, 8'h07);
    wr(8, 8'hFF);
    rd(8, v); check("R11 ctrl mask", v, 8'h80);
    wr(3, 8'h80 | exp_byte(3));
    rd(3, v); check("R11 hour mask", v, exp_byte(3));
    for (int a = 9; a < 16; a++) begin rd(a, v); check("R11 unmapped", v, 8'h00); end

    // R12: direct write while transfer enabled
    wr(1, 8'h42); m_s = 42;
    rd(1, v); check("R12 write", v, 8'h42);
    tick_n(3);
    check_all("R12 continues");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule